// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a single stage of a synchronous binary up-counter. The default width is four bits, so the stage counts modulo sixteen. An active-low load input copies a parallel word into the register on a rising clock edge. Counting needs two active-high enables at the same time. The first is a parallel enable that all stages of a chain share. The second is a trickle enable that passes from stage to stage.

The terminal-count output goes high when the register holds its all-ones value and the trickle enable is high. Wiring that output to the trickle enable of the next stage builds a wider counter. Every stage of such a chain advances on the same clock edge, with no ripple between stages.

A build-time parameter selects how the active-low clear behaves. In one variant it clears the register at once, with no wait for the clock. In the other it clears the register on the next rising edge.

Top module: `presettable_counter`

## Requirements
- R1: The count is taken modulo 2^WIDTH. When a stage counts from its all-ones value (15 at the default width), the next state is 0.
- R2: With ASYNC_CLR=1, a low on `clr_n` forces `q` to 0 at once. This happens between clock edges too, and no other input can prevent it.
- R3: With ASYNC_CLR=0, a low on `clr_n` at a rising edge sets `q` to 0 on that edge, even when `load_n` is low or both enables are high. A low pulse on `clr_n` that covers no rising edge leaves `q` unchanged.
- R4: When the clear is inactive and `load_n` is low, the next rising edge copies `din` into `q`, whatever the two enables are.
- R5: When the clear is inactive, `load_n` is high and both `cnt_en_par` and `cnt_en_trk` are high, `q` increments by one on each rising edge.
- R6: When the clear is inactive, `load_n` is high and either enable is low, `q` keeps its value across the edge.
- R7: `term_cnt` is combinational. It is 1 exactly when `q` is all ones and `cnt_en_trk` is 1, and `cnt_en_par` has no effect on it. When `cnt_en_trk` falls while `q` is all ones, `term_cnt` falls in the same cycle.
- R8: In a chain of two stages, where the low stage's `term_cnt` drives the high stage's `cnt_en_trk`, both stages share clock, `load_n` and `cnt_en_par`, and the combined value counts through all 2^(2*WIDTH) states in order, with both stages changing on the same edge.
- R9: After `clr_n` has been low across a rising edge, `q` is 0 and `term_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all changes except the immediate clear happen on its rising edge |
| clr_n | input | 1 | Active-low clear; immediate or clocked according to ASYNC_CLR |
| load_n | input | 1 | Active-low parallel load |
| cnt_en_par | input | 1 | Parallel count enable, shared by all stages of a chain |
| cnt_en_trk | input | 1 | Trickle count enable; also gates term_cnt |
| din | input | WIDTH | Parallel data loaded when load_n is low |
| q | output | WIDTH | Counter state |
| term_cnt | output | 1 | High when q is all ones and cnt_en_trk is high |

## Verification
The bench applies four conflicts that test the mode priority. Load and count are requested together, and a design that lets count win increments instead of loading. Clear and load are requested together, and a wrong priority leaves the loaded word in place of zero. A clear pulse arrives between two edges: an immediate-clear stage that waits for the clock keeps its old value, and a clocked stage that reacts at once drops to zero. The trickle enable is dropped while the state is fifteen, and a terminal count gated by the wrong enable stays high. A two-stage chain then runs through all 256 states, so a carry taken from the wrong signal shows up as a skipped or repeated high nibble.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic [1:0] {
        MD_CLEAR = 2'd0,
        MD_LOAD  = 2'd1,
        MD_COUNT = 2'd2,
        MD_HOLD  = 2'd3
    } mode_e;

    // Fixed precedence: clear, load, count, hold.
    function automatic mode_e pick_mode(input logic clr_now, input logic load_n,
                                        input logic en_par, input logic en_trk);
        if (clr_now)
            return MD_CLEAR;
        else if (!load_n)
            return MD_LOAD;
        else if (en_par && en_trk)
            return MD_COUNT;
        else
            return MD_HOLD;
    endfunction

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
    import pcnt_pkg::*;
#(
    parameter bit CLOCKED_CLR = 1'b1
) (
    input  logic  clr_n,
    input  logic  load_n,
    input  logic  en_par,
    input  logic  en_trk,
    output mode_e mode
);
    logic clr_now;

    generate
        if (CLOCKED_CLR) begin : g_clk_clr
            assign clr_now = ~clr_n;
        end else begin : g_no_clk_clr
            assign clr_now = 1'b0;
        end
    endgenerate

    always_comb mode = pick_mode(clr_now, load_n, en_par, en_trk);
endmodule

// File: rtl/ctr_next.sv
module ctr_next
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e             mode,
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MD_CLEAR: nxt = '0;
            MD_LOAD:  nxt = din;
            MD_COUNT: nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur
);
    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) cur <= '0;
                else        cur <= nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                cur <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_trk,
    output logic             tc
);
    always_comb tc = en_trk & (&cur);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en_par,
    input  logic             cnt_en_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             term_cnt
);
    localparam bit CLOCKED_CLR = !ASYNC_CLR;

    mode_e            mode;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] cur;

    ctr_mode_sel #(.CLOCKED_CLR(CLOCKED_CLR)) u_mode (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (cnt_en_par),
        .en_trk (cnt_en_trk),
        .mode   (mode)
    );

    ctr_next #(.WIDTH(WIDTH)) u_next (
        .mode (mode),
        .cur  (cur),
        .din  (din),
        .nxt  (nxt)
    );

    ctr_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    ctr_tc #(.WIDTH(WIDTH)) u_tc (
        .cur    (cur),
        .en_trk (cnt_en_trk),
        .tc     (term_cnt)
    );

    assign q = cur;
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b1
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             cnt_en_par,
    input logic             cnt_en_trk,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             term_cnt
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    // Set by any clear pulse, dropped at the following edge.
    logic clr_hit;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) clr_hit <= 1'b1;
        else        clr_hit <= 1'b0;
    end

    generate
        if (ASYNC_CLR) begin : g_async
            a_r2_async_clear: assert property (@(posedge clk)
                (!clr_n) |-> (q == '0));
        end else begin : g_sync
            a_r3_sync_clear: assert property (@(posedge clk)
                (!clr_n) |=> (q == '0));
        end
    endgenerate

    a_r4_load: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (!load_n) |=> (q == $past(din)));

    a_r5_count: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (load_n && cnt_en_par && cnt_en_trk) |=> (q == $past(q) + ONE));

    a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (load_n && !(cnt_en_par && cnt_en_trk)) |=> $stable(q));

    a_r1_wrap: assert property (@(posedge clk) disable iff (!clr_n || clr_hit)
        (load_n && cnt_en_par && term_cnt) |=> (q == '0));

    a_r7_tc_needs_trk: assert property (@(posedge clk) disable iff (!clr_n)
        term_cnt |-> (cnt_en_trk && q == ALL_ONES));

    a_r7_tc_when_full: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt_en_trk && q == ALL_ONES) |-> term_cnt);
endmodule

bind presettable_counter ctr_checker #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk        (clk),
    .clr_n      (clr_n),
    .load_n     (load_n),
    .cnt_en_par (cnt_en_par),
    .cnt_en_trk (cnt_en_trk),
    .din        (din),
    .q          (q),
    .term_cnt   (term_cnt)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;
    localparam int W = 4;
    localparam logic [W-1:0] FULL = '1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic         ep = 1'b0;
    logic         et = 1'b0;
    logic [W-1:0] din_lo = '0;
    logic [W-1:0] din_hi = '0;

    logic [W-1:0] q_lo, q_hi, q_s;
    logic         tc_lo, tc_hi, tc_s;

    presettable_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_par(ep),
        .cnt_en_trk(et), .din(din_lo), .q(q_lo), .term_cnt(tc_lo));

    presettable_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_par(ep),
        .cnt_en_trk(tc_lo), .din(din_hi), .q(q_hi), .term_cnt(tc_hi));

    presettable_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) dut_sync (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_par(ep),
        .cnt_en_trk(et), .din(din_lo), .q(q_s), .term_cnt(tc_s));

    // Arithmetic model built from the requirements.
    logic [W-1:0] m_lo, m_hi, m_s;

    function automatic logic [W-1:0] step_val(input logic [W-1:0] v, input logic ld_n,
                                              input logic p, input logic t,
                                              input logic [W-1:0] d);
        if (!ld_n)      return d;
        else if (p & t) return W'((int'(v) + 1) % (1 << W));
        else            return v;
    endfunction

    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            m_lo <= '0;
            m_hi <= '0;
        end else begin
            m_lo <= step_val(m_lo, load_n, ep, et, din_lo);
            m_hi <= step_val(m_hi, load_n, ep, et && (m_lo == FULL), din_hi);
        end
    end

    always @(posedge clk) begin
        if (!clr_n) m_s <= '0;
        else        m_s <= step_val(m_s, load_n, ep, et, din_lo);
    end

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R9";
    bit    bg_on = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Background comparison away from the active edge.
    always @(negedge clk) begin
        if (bg_on) begin
            chk(cur_tag, "async stage q", int'(q_lo), int'(m_lo));
            chk(cur_tag, "sync stage q",  int'(q_s),  int'(m_s));
            chk("R8", "high stage q", int'(q_hi), int'(m_hi));
            chk("R7", "low tc",  int'(tc_lo), int'(et && m_lo == FULL));
            chk("R7", "sync tc", int'(tc_s),  int'(et && m_s == FULL));
            chk("R8", "high tc", int'(tc_hi), int'(et && m_lo == FULL && m_hi == FULL));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R9: reset state
        cur_tag = "R9";
        repeat (3) cyc();
        bg_on = 1'b1;
        chk("R9", "q after clear", int'(q_lo), 0);
        chk("R9", "tc after clear", int'(tc_lo), 0);
        clr_n = 1'b1;

        // R4: load every value under every enable combination (load wins)
        cur_tag = "R4";
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 4; e++) begin
                load_n = 1'b0; din_lo = W'(v); din_hi = W'(15 - v);
                ep = e[0]; et = e[1];
                cyc();
                @(negedge clk);
                chk("R4", "loaded value", int'(q_s), v);
                #5;
            end
        end
        load_n = 1'b1;

        // R6: hold for each state under each disabling combination
        cur_tag = "R6";
        for (int v = 0; v < 16; v++) begin
            load_n = 1'b0; din_lo = W'(v); cyc();
            load_n = 1'b1;
            for (int e = 0; e < 3; e++) begin
                ep = e[0]; et = e[1];
                cyc();
            end
        end

        // R5 / R1 / R8: full sweep of the two-stage chain
        cur_tag = "R5";
        load_n = 1'b0; din_lo = '0; din_hi = '0; cyc();
        load_n = 1'b1; ep = 1'b1; et = 1'b1;
        for (int k = 1; k <= 260; k++) begin
            cur_tag = (m_lo == FULL) ? "R1" : "R5";
            cyc();
            @(negedge clk);
            chk("R8", "chain value", int'({q_hi, q_lo}), k % 256);
            #5;
        end

        // R7: trickle enable drops while the state is all ones
        cur_tag = "R7";
        load_n = 1'b0; din_lo = FULL; cyc();
        load_n = 1'b1; ep = 1'b0; et = 1'b1;
        #2;
        chk("R7", "tc with trk high, par low", int'(tc_lo), 1);
        et = 1'b0;
        #1;
        chk("R7", "tc after trk falls", int'(tc_lo), 0);
        et = 1'b1; ep = 1'b1;
        #1;
        chk("R7", "tc with both high", int'(tc_s), 1);
        ep = 1'b0;
        cyc();

        // R3: clear together with load and count
        cur_tag = "R3";
        load_n = 1'b0; din_lo = 4'd9; ep = 1'b1; et = 1'b1; clr_n = 1'b0;
        cyc();
        @(negedge clk);
        chk("R3", "sync clear beats load", int'(q_s), 0);
        chk("R2", "async clear beats load", int'(q_lo), 0);
        #5;
        clr_n = 1'b1; load_n = 1'b0; din_lo = 4'd6; ep = 1'b0; cyc();
        load_n = 1'b1;
        cyc();

        // R2: clear pulse between edges
        cur_tag = "R2";
        clr_n = 1'b0;
        #2;
        chk("R2", "async stage cleared mid-cycle", int'(q_lo), 0);
        chk("R3", "sync stage ignores edge-free pulse", int'(q_s), 6);
        #1;
        clr_n = 1'b1;
        cyc();
        @(negedge clk);
        chk("R3", "sync stage kept value", int'(q_s), 6);
        chk("R2", "async stage stays clear", int'(q_lo), 0);
        #5;
        bg_on = 1'b0;
        finish_run();
    end
endmodule